// File: doc/BRIEF.md
# Codec Bit-Clock and Frame-Sync Generator

This block derives the two timing signals a PCM codec and a local serial port need from one master clock. With a 19.2 MHz master clock it produces a 256 kHz bit clock with a 50% duty cycle and an 8 kHz frame-sync strobe. The strobe is high for exactly one bit-clock period, and it rises together with a bit-clock rising edge. The ratio of master clock to bit clock is 75, which is odd. The bit clock therefore combines a rising-edge counter term with a copy of that term taken on the falling edge, so the high phase is 37.5 master periods long.

A power-down input stops both outputs and holds them low. When power-down is released, both dividers restart from zero, so the first frame after release has its full length. Power-down is accepted only after a settle window of master cycles has followed reset release. The reset input clears that settle window and nothing else. The bit clock and frame strobe keep running through reset without a phase step, so a codec that shares them is not disturbed.

Top module: `codec_clkgen`

## Requirements
- R1: The bit clock `bclk_o` has a period of exactly MCLK_HZ/BCLK_HZ master cycles (75 by default, 300 ns at the bench clock).
- R2: The bit clock is high for (DIV-1)/2 + 1/2 master periods when the ratio DIV is odd (37.5 periods, 150 ns at the bench clock), and DIV/2 periods when DIV is even.
- R3: Frame-sync rising edges are BCLK_HZ/FRAME_HZ bit-clock periods apart (32 periods, 2400 master cycles), with exactly that many bit-clock rising edges between them.
- R4: `fsync_o` rises at the same instant as a bit-clock rising edge and stays high for exactly one bit-clock period.
- R5: While power-down is in effect, `bclk_o` and `fsync_o` are both low. Power-down takes effect on the master edge after `pd_i` is sampled high (once the settle window has passed) and stays in effect while `pd_i` remains high.
- R6: For the first PD_GUARD_CYC master rising edges after reset release (10 by default), a high `pd_i` has no effect. The outputs keep their phase grid, and after the window a held `pd_i` takes effect.
- R7: When `pd_i` is sampled low, both outputs rise on that same master rising edge (half a master period after `pd_i` is driven low on a falling edge). The next frame-sync rise follows a full frame later.
- R8: Asserting `rst_n_i` (low) does not move the bit-clock or frame-sync edges. The outputs stay on the grid they had before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock (nominally 19.2 MHz) |
| rst_n_i | input | 1 | Active-low synchronous reset; clears only the power-down settle window |
| pd_i | input | 1 | Power-down request, active high |
| bclk_o | output | 1 | Bit clock to codec and serial port, 50% duty |
| fsync_o | output | 1 | Frame-sync strobe, one bit-clock period wide |

## Verification
The bench builds the block with its default parameters: a 19.2 MHz master clock, a 256 kHz bit clock, an 8 kHz frame and a 10-cycle settle window. This gives an odd ratio of 75, so the dual-edge half-period path is the one elaborated, and 32 bit clocks make up each frame. Because the ratio is odd, the bench can measure a 150 ns high phase against a 300 ns period and confirm the extra half period that the falling-edge term adds. With the short settle window, the bench can place a power-down pulse wholly inside the window after reset and then show that the frame grid does not move. The even-ratio branch is not elaborated at these values.

// File: rtl/codec_clkgen_pkg.sv
// Package: codec_clkgen_pkg
// Shared helpers for the codec clock generator.
// Assumes: counts passed in are at least 1.
package codec_clkgen_pkg;

    // Width needed to hold values 0..n-1, never below one bit.
    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = $clog2(n);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/clkgen_pd_ctrl.sv
// Module: clkgen_pd_ctrl
// Decides when a power-down request actually takes effect. Entry is blocked
// until GUARD_CYC master edges have followed reset release. Once active, the
// power-down holds for as long as the request stays high. Also flags when the
// dividers are in a known phase (they have been held at zero since reset).
// Assumes: rst_n_i is synchronous to clk_i. Reset never clears pd_act_o,
// so reset on its own never disturbs the outputs.
module clkgen_pd_ctrl
    import codec_clkgen_pkg::*;
#(
    parameter int unsigned GUARD_CYC = 10
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pd_i,
    output logic pd_act_o,
    output logic phase_known_o
);

    localparam int unsigned GW = cnt_width(GUARD_CYC + 1);
    localparam logic [GW-1:0] GUARD_END = GW'(GUARD_CYC);

    logic [GW-1:0] guard_q;
    logic          guard_done;
    logic          pd_act_q;
    logic          known_q;

    assign guard_done = (guard_q == GUARD_END);

    // Count master edges since reset release, saturating at the window end.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            guard_q <= '0;
        end else if (!guard_done) begin
            guard_q <= guard_q + 1'b1;
        end
    end

    // Enter power-down after the window; leave it as soon as the request drops.
    always_ff @(posedge clk_i) begin
        pd_act_q <= pd_i && (pd_act_q || guard_done);
    end

    // Record that the dividers have been forced to zero since the last reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            known_q <= 1'b0;
        end else if (pd_act_q) begin
            known_q <= 1'b1;
        end
    end

    assign pd_act_o      = pd_act_q;
    assign phase_known_o = known_q;

    AST_PD_GUARD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!pd_act_q && !guard_done) |=> !pd_act_q); // R6
    AST_PD_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (pd_act_q && pd_i) |=> pd_act_q); // R5
    AST_PD_TAKES_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (pd_i && guard_done) |=> pd_act_q); // R5

endmodule

// File: rtl/clkgen_bit_div.sv
// Module: clkgen_bit_div
// Divides the master clock by DIV to form the bit clock. An odd DIV adds a
// falling-edge copy of the high term, which stretches the high phase by half
// a master period so that the duty cycle is within half a period of 50%.
// Also emits a one-cycle pulse on the master cycle before each bit-clock rise.
// Assumes: DIV >= 2. hold_i forces the count to zero. The count recovers from
// any out-of-range value.
module clkgen_bit_div
    import codec_clkgen_pkg::*;
#(
    parameter int unsigned DIV = 75
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic hold_i,
    input  logic chk_en_i,
    output logic bclk_o,
    output logic wrap_o
);

    localparam int unsigned CW       = cnt_width(DIV);
    localparam int unsigned HALF     = (DIV % 2 == 1) ? (DIV - 1) / 2 : DIV / 2;
    localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF_C = CW'(HALF);

    logic [CW-1:0] cnt_q;
    logic          hi;

    // Master-cycle position within one bit-clock period.
    always_ff @(posedge clk_i) begin
        if (hold_i || cnt_q >= LAST_C) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hi     = (cnt_q < HALF_C);
    assign wrap_o = !hold_i && (cnt_q == LAST_C);

    generate
        if (DIV % 2 == 1) begin : g_odd
            logic lag_q;

            // Falling-edge copy of the high term, half a master period late.
            always_ff @(negedge clk_i) begin
                lag_q <= hi;
            end

            assign bclk_o = hi | lag_q;
        end else begin : g_even
            assign bclk_o = hi;
        end
    endgenerate

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i || !chk_en_i)
        cnt_q <= LAST_C); // R1
    AST_WRAP_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_n_i || !chk_en_i)
        wrap_o |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/clkgen_frame_div.sv
// Module: clkgen_frame_div
// Counts bit-clock periods within a frame and raises the frame strobe for
// the whole first period of each frame.
// Assumes: tick_i pulses once per bit-clock period, on the master cycle that
// ends it. hold_i forces the frame back to its first period.
module clkgen_frame_div
    import codec_clkgen_pkg::*;
#(
    parameter int unsigned BITS = 32
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic hold_i,
    input  logic tick_i,
    input  logic chk_en_i,
    output logic fsync_o
);

    localparam int unsigned BW       = cnt_width(BITS);
    localparam logic [BW-1:0] LAST_C = BW'(BITS - 1);

    logic [BW-1:0] bit_q;

    // Bit-clock period index within the frame.
    always_ff @(posedge clk_i) begin
        if (hold_i) begin
            bit_q <= '0;
        end else if (tick_i) begin
            bit_q <= (bit_q >= LAST_C) ? '0 : bit_q + 1'b1;
        end
    end

    assign fsync_o = (bit_q == '0);

    AST_BIT_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_n_i || !chk_en_i)
        (!tick_i && !hold_i) |=> $stable(bit_q)); // R3
    AST_BIT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i || !chk_en_i)
        bit_q <= LAST_C); // R3

endmodule

// File: rtl/codec_clkgen.sv
// Module: codec_clkgen
// Top of the codec timing generator. Produces a bit clock and a frame strobe
// from the master clock, gates both low in power-down, and restarts both
// dividers from zero when power-down ends.
// Assumes: MCLK_HZ is a whole multiple of BCLK_HZ, and BCLK_HZ is a whole
// multiple of FRAME_HZ. Reset acts only on the power-down settle window.
module codec_clkgen
#(
    parameter int unsigned MCLK_HZ      = 19_200_000,
    parameter int unsigned BCLK_HZ      = 256_000,
    parameter int unsigned FRAME_HZ     = 8_000,
    parameter int unsigned PD_GUARD_CYC = 10
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pd_i,
    output logic bclk_o,
    output logic fsync_o
);

    localparam int unsigned DIV  = MCLK_HZ / BCLK_HZ;
    localparam int unsigned BITS = BCLK_HZ / FRAME_HZ;

    logic pd_act;
    logic phase_known;
    logic bclk_raw;
    logic bit_wrap;
    logic fsync_raw;

    clkgen_pd_ctrl #(
        .GUARD_CYC (PD_GUARD_CYC)
    ) pd_ctrl_i (
        .clk_i         (clk_i),
        .rst_n_i       (rst_n_i),
        .pd_i          (pd_i),
        .pd_act_o      (pd_act),
        .phase_known_o (phase_known)
    );

    clkgen_bit_div #(
        .DIV (DIV)
    ) bit_div_i (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .hold_i   (pd_act),
        .chk_en_i (phase_known),
        .bclk_o   (bclk_raw),
        .wrap_o   (bit_wrap)
    );

    clkgen_frame_div #(
        .BITS (BITS)
    ) frame_div_i (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .hold_i   (pd_act),
        .tick_i   (bit_wrap),
        .chk_en_i (phase_known),
        .fsync_o  (fsync_raw)
    );

    // Power-down gating of both outputs.
    assign bclk_o  = bclk_raw  && !pd_act;
    assign fsync_o = fsync_raw && !pd_act;

    AST_PD_OUTPUTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pd_act |-> (!bclk_o && !fsync_o)); // R5
    AST_FSYNC_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_n_i || !phase_known)
        $rose(fsync_o) |-> $rose(bclk_o)); // R4
    AST_FSYNC_FALL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_n_i || !phase_known)
        ($fell(fsync_o) && !pd_act) |-> $rose(bclk_o)); // R4
    AST_RESTART_ON_EXIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(pd_act) |-> (bclk_o && fsync_o)); // R7

endmodule

// File: tb/codec_clkgen_tb_top.sv
// Bench: codec_clkgen_tb_top
// Directed scenarios, one task each. Timing is measured from output edge times.
// Clock is 250 MHz: posedges at 2, 6, 10 ns and so on; inputs are driven on falling edges.
`timescale 1ns/1ps
module codec_clkgen_tb_top;

    localparam longint T_CLK   = 4;
    localparam longint DIV     = 75;
    localparam longint BITS    = 32;
    localparam longint T_BCLK  = DIV * T_CLK;       // 300 ns
    localparam longint T_HIGH  = 150;               // 37.5 master periods
    localparam longint T_FRAME = T_BCLK * BITS;     // 9600 ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd = 1'b0;
    logic bclk;
    logic fsync;

    int checks = 0;
    int errors = 0;
    longint last_bclk_rise = 0;
    int bclk_rises = 0;

    always #2 clk = ~clk;

    codec_clkgen dut_i (
        .clk_i   (clk),
        .rst_n_i (rst_n),
        .pd_i    (pd),
        .bclk_o  (bclk),
        .fsync_o (fsync)
    );

    // Track bit-clock rising edges for alignment and counting.
    always @(posedge bclk) begin
        last_bclk_rise = $time;
        bclk_rises     = bclk_rises + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Power-down holds outputs low; release restarts them with a full frame.
    task automatic t_pd_restart();
        bit all_low;
        longint t_drop, t_b, t_f;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (14) @(negedge clk);
        pd = 1'b1;
        repeat (3) @(negedge clk);
        all_low = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (bclk || fsync) all_low = 1'b0;
        end
        chk(all_low, "R5", "outputs low in power-down", all_low, 1);
        @(negedge clk);
        pd = 1'b0;
        t_drop = $time;
        @(posedge bclk);
        t_b = $time;
        chk(t_b - t_drop == 2, "R7", "bclk rise after release (ns)", t_b - t_drop, 2);
        #1;
        chk(fsync == 1'b1, "R7", "fsync high with first bclk", fsync, 1);
        @(posedge fsync);
        t_f = $time;
        chk(t_f - t_b == T_FRAME, "R7", "first frame length (ns)", t_f - t_b, T_FRAME);
    endtask

    // Bit-clock period and high time.
    task automatic t_bclk_shape();
        longint tr, tf, tr2;
        for (int i = 0; i < 3; i++) begin
            @(posedge bclk); tr = $time;
            @(negedge bclk); tf = $time;
            @(posedge bclk); tr2 = $time;
            chk(tf - tr == T_HIGH, "R2", "bclk high time (ns)", tf - tr, T_HIGH);
            chk(tr2 - tr == T_BCLK, "R1", "bclk period (ns)", tr2 - tr, T_BCLK);
        end
    endtask

    // Frame strobe alignment, width and frame length.
    task automatic t_fsync_shape();
        longint t0, t1, t2;
        int n0;
        @(posedge fsync); t0 = $time; #1;
        n0 = bclk_rises;
        chk(last_bclk_rise == t0, "R4", "fsync rise vs bclk rise (ns)", last_bclk_rise, t0);
        @(negedge fsync); t1 = $time;
        chk(t1 - t0 == T_BCLK, "R4", "fsync width (ns)", t1 - t0, T_BCLK);
        @(posedge fsync); t2 = $time; #1;
        chk(t2 - t0 == T_FRAME, "R3", "frame period (ns)", t2 - t0, T_FRAME);
        chk(bclk_rises - n0 == BITS, "R3", "bclk rises per frame", bclk_rises - n0, BITS);
    endtask

    // Reset must leave the output edges on their grid.
    task automatic t_reset_quiet();
        longint t0, t1;
        @(posedge fsync); t0 = $time; #1;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (400) @(negedge clk);
        chk((last_bclk_rise - t0) % T_BCLK == 0 && last_bclk_rise > t0, "R8",
            "bclk grid offset during reset (ns)", (last_bclk_rise - t0) % T_BCLK, 0);
        rst_n = 1'b1;
        @(posedge fsync); t1 = $time;
        chk(t1 - t0 == T_FRAME, "R8", "frame period across reset (ns)", t1 - t0, T_FRAME);
    endtask

    // A power-down request inside the settle window is ignored; later it takes effect.
    task automatic t_guard();
        longint t_ref, t_b, t_f;
        @(posedge fsync); t_ref = $time; #1;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pd = 1'b1;
        repeat (6) @(negedge clk);
        pd = 1'b0;
        @(posedge bclk); t_b = $time;
        chk((t_b - t_ref) % T_BCLK == 0, "R6", "bclk grid offset after early request (ns)",
            (t_b - t_ref) % T_BCLK, 0);
        @(posedge fsync); t_f = $time; #1;
        chk((t_f - t_ref) % T_FRAME == 0, "R6", "frame grid offset after early request (ns)",
            (t_f - t_ref) % T_FRAME, 0);
        repeat (20) @(negedge clk);
        pd = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!bclk && !fsync, "R6", "request honoured after window", {bclk, fsync}, 0);
        @(negedge clk);
        pd = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_pd_restart();
        t_bclk_shape();
        t_fsync_shape();
        t_reset_quiet();
        t_guard();
        t_fsync_shape();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule